// File: doc/BRIEF.md
# Shadow-Buffered PWM Timer

This block produces one pulse-width modulated output from a free-running tick counter. Software sets it up through a small register bus: an address, a write strobe, write data and a combinational read-data return. Each waveform period lasts a programmed number of clock ticks. The output sits at its active level for a programmed number of ticks at the start of each period and at its inactive level for the rest. Both levels are selectable.

Period, duty and the two level-select bits are never applied directly. Writes land in shadow storage and move into the running set only when the counter wraps, so every pulse is whole. A lock bit in the control word holds back that transfer. Software can set the lock, rewrite period, duty and polarity in any order, and then clear the lock. All the new values then take effect together at the start of the next period. While the timer is disabled, the counter rests at zero and the output shows the inactive level.

Top module: `pwm_shadow_timer`

## Requirements
- R1: After reset, the counter, period and duty read as 0, the control word reads 0x18 (both level bits set), and the output is high.
- R2: The bus addresses are 0x4 for period, 0x8 for duty and 0xC for control. A write becomes readable on the next cycle. Control keeps bits 0 to 6 and bit 8. Bit 7 and all bits above 8 read as 0. Bits [2:1] (continuous mode = 01), bit 5 (0 = left-aligned) and bit 8 (low-power off) are stored only.
- R3: Address 0x0 returns the live counter value. Writes to 0x0 change no register and do not disturb the count.
- R4: When control bit 0 (enable) is 1, the counter advances by one every clock. After it reaches period minus 1, it returns to 0. With period 0 or 1, it stays at 0.
- R5: While the timer is enabled, the output is at the active level when the count is below duty, and at the inactive level otherwise. Duty 0 gives a constant inactive level. A duty at or above period gives a constant active level.
- R6: Control bit 3 selects the active level (1 = high) and control bit 4 selects the inactive level (1 = high).
- R7: With enable at 0, the count is held at 0 and the output is at the inactive level. If the lock is clear, shadow values are copied into the running set on every cycle.
- R8: With the lock clear and the timer running, newly written period, duty or level bits change the waveform only from the next wrap onward.
- R9: While control bit 6 (lock) is 1, period, duty and level writes are stored and read back, but the waveform keeps its running values, even across wraps.
- R10: After the lock is cleared, the pending period, duty and level bits all take effect together at the next wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one counter tick per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register byte address |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwm_out | output | 1 | Modulated output |

## Verification
Reads are combinational, so the counter value is visible in the same cycle. A register write shows on a read one cycle after the edge that samples it. A change of enable shows on the count and output one cycle after its write. A new period, duty or level setting shows only in the cycle after the wrap edge that follows it, or later if the lock is held. A behavioural model in the bench advances at each rising edge from the bus values sampled there. It is compared with the output and the read data at the following falling edge, so every result is checked in exactly the cycle it is due. Directed checks measure whole windows that are a multiple of the period, and only after enough cycles for any pending wrap to have passed.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    localparam int OFF_COUNT  = 'h0;
    localparam int OFF_PERIOD = 'h4;
    localparam int OFF_DUTY   = 'h8;
    localparam int OFF_CTRL   = 'hC;

    localparam int CTRL_W     = 9;
    localparam int B_ENABLE   = 0;
    localparam int B_ACT_HI   = 3;
    localparam int B_IDLE_HI  = 4;
    localparam int B_LOCK     = 6;

    localparam logic [CTRL_W-1:0] CTRL_RST   = 9'h018;
    localparam logic [CTRL_W-1:0] CTRL_WMASK = 9'h17F;

    typedef struct packed {
        logic act_hi;
        logic idle_hi;
    } pol_t;

    localparam pol_t POL_RST = '{act_hi: 1'b1, idle_hi: 1'b1};

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              we_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [CNT_W-1:0]  cnt_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic [CNT_W-1:0]  per_o,
    output logic [CNT_W-1:0]  duty_o,
    output logic [CTRL_W-1:0] ctrl_o
);

    typedef struct packed {
        logic [CNT_W-1:0]  per;
        logic [CNT_W-1:0]  duty;
        logic [CTRL_W-1:0] ctrl;
    } regs_t;

    regs_t r_d, r_q;
    logic  unused_wdata;

    assign unused_wdata = ^wdata_i[DATA_W-1:CNT_W];

    always_comb begin
        r_d = r_q;
        if (we_i) begin
            case (addr_i)
                ADDR_W'(OFF_PERIOD): r_d.per  = wdata_i[CNT_W-1:0];
                ADDR_W'(OFF_DUTY):   r_d.duty = wdata_i[CNT_W-1:0];
                ADDR_W'(OFF_CTRL):   r_d.ctrl = wdata_i[CTRL_W-1:0] & CTRL_WMASK;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{per: '0, duty: '0, ctrl: CTRL_RST};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            ADDR_W'(OFF_COUNT):  rdata_o = DATA_W'(cnt_i);
            ADDR_W'(OFF_PERIOD): rdata_o = DATA_W'(r_q.per);
            ADDR_W'(OFF_DUTY):   rdata_o = DATA_W'(r_q.duty);
            ADDR_W'(OFF_CTRL):   rdata_o = DATA_W'(r_q.ctrl);
            default: ;
        endcase
    end

    assign per_o  = r_q.per;
    assign duty_o = r_q.duty;
    assign ctrl_o = r_q.ctrl;

    // R3: a write aimed at the counter address leaves every register alone
    assert_count_write_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && addr_i == ADDR_W'(OFF_COUNT)) |=>
            ($stable(r_q.per) && $stable(r_q.duty) && $stable(r_q.ctrl)));

    // R2: bit 7 of the control word can never be set
    assert_ctrl_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (r_q.ctrl[7] == 1'b0));

endmodule

// File: rtl/pwm_core.sv
module pwm_core
    import pwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             lock_i,
    input  logic [CNT_W-1:0] sh_per_i,
    input  logic [CNT_W-1:0] sh_duty_i,
    input  pol_t             sh_pol_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             pwm_o
);

    localparam logic [CNT_W:0]   ONE_X = (CNT_W+1)'(1);
    localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] per;
        logic [CNT_W-1:0] duty;
        pol_t             pol;
    } core_t;

    core_t s_d, s_q;
    logic  wrap;

    always_comb begin
        s_d  = s_q;
        wrap = ({1'b0, s_q.cnt} + ONE_X) >= {1'b0, s_q.per};
        if (!en_i || wrap) begin
            s_d.cnt = '0;
            if (!lock_i) begin
                s_d.per  = sh_per_i;
                s_d.duty = sh_duty_i;
                s_d.pol  = sh_pol_i;
            end
        end else begin
            s_d.cnt = s_q.cnt + ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{cnt: '0, per: '0, duty: '0, pol: POL_RST};
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt_o = s_q.cnt;
    assign pwm_o = (en_i && (s_q.cnt < s_q.duty)) ? s_q.pol.act_hi : s_q.pol.idle_hi;

    // R4: the count never reaches the running period
    assert_cnt_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.per != '0) |-> (s_q.cnt < s_q.per));

    // R4: a nonzero count is always one more than the previous one
    assert_cnt_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.cnt != '0) |-> (s_q.cnt == $past(s_q.cnt) + ONE));

    // R7: disabled timer parks the counter
    assert_hold_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (s_q.cnt == '0));

    // R8: running values change only when the counter returns to zero
    assert_apply_on_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        en_i |=> ((s_q.cnt == '0) || ($stable(s_q.per) && $stable(s_q.duty) && $stable(s_q.pol))));

    // R9: locked running set does not move
    assert_locked_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        lock_i |=> ($stable(s_q.per) && $stable(s_q.duty) && $stable(s_q.pol)));

endmodule

// File: rtl/pwm_shadow_timer.sv
module pwm_shadow_timer
    import pwm_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              pwm_out
);

    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  sh_per;
    logic [CNT_W-1:0]  sh_duty;
    logic [CTRL_W-1:0] ctrl;
    pol_t              sh_pol;
    logic              unused_ctrl;

    assign sh_pol      = '{act_hi: ctrl[B_ACT_HI], idle_hi: ctrl[B_IDLE_HI]};
    assign unused_ctrl = ^{ctrl[2:1], ctrl[5], ctrl[7], ctrl[8]};

    pwm_regs #(
        .CNT_W (CNT_W),
        .DATA_W(DATA_W),
        .ADDR_W(ADDR_W)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr_i (bus_addr),
        .we_i   (bus_we),
        .wdata_i(bus_wdata),
        .cnt_i  (cnt),
        .rdata_o(bus_rdata),
        .per_o  (sh_per),
        .duty_o (sh_duty),
        .ctrl_o (ctrl)
    );

    pwm_core #(
        .CNT_W(CNT_W)
    ) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (ctrl[B_ENABLE]),
        .lock_i   (ctrl[B_LOCK]),
        .sh_per_i (sh_per),
        .sh_duty_i(sh_duty),
        .sh_pol_i (sh_pol),
        .cnt_o    (cnt),
        .pwm_o    (pwm_out)
    );

endmodule

// File: tb/pwm_shadow_timer_bench.sv
`timescale 1ns/1ps
module pwm_shadow_timer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        pwm_out;

    int total = 0;
    int bad = 0;
    bit done = 0;
    string phase = "R1";

    always #2.5 clk = ~clk;

    pwm_shadow_timer u_pwm_shadow_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_we   (bus_we),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .pwm_out  (pwm_out)
    );

    // behavioural reference
    int m_cnt, m_per, m_duty, m_act, m_idle;
    int s_per, s_duty, s_ctrl;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_per = 0; m_duty = 0; m_act = 1; m_idle = 1;
            s_per = 0; s_duty = 0; s_ctrl = 'h18;
        end else begin
            bit on, held;
            on   = s_ctrl[0];
            held = s_ctrl[6];
            if (!on || (m_cnt + 1 >= m_per)) begin
                m_cnt = 0;
                if (!held) begin
                    m_per = s_per; m_duty = s_duty;
                    m_act = s_ctrl[3]; m_idle = s_ctrl[4];
                end
            end else begin
                m_cnt = m_cnt + 1;
            end
            if (bus_we) begin
                case (bus_addr)
                    4'h4: s_per  = bus_wdata & 'hFFFF;
                    4'h8: s_duty = bus_wdata & 'hFFFF;
                    4'hC: s_ctrl = bus_wdata & 'h17F;
                    default: ;
                endcase
            end
        end
    end

    function automatic int exp_rd(input logic [3:0] a);
        case (a)
            4'h0: return m_cnt;
            4'h4: return s_per;
            4'h8: return s_duty;
            4'hC: return s_ctrl;
            default: return 0;
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            int e_out;
            e_out = (s_ctrl[0] && m_cnt < m_duty) ? m_act : m_idle;
            check(phase, int'(pwm_out), e_out);
            check(phase, int'(bus_rdata), exp_rd(bus_addr));
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); #1;
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk); #1;
        bus_we = 1'b0; bus_addr = 4'h0;
    endtask

    task automatic rd(input logic [3:0] a, output int d);
        @(negedge clk); #1;
        bus_addr = a;
        @(negedge clk);
        d = int'(bus_rdata);
        #1 bus_addr = 4'h0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic count_high(input int n, output int h);
        h = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_out) h++;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        total++; bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int v, h;
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        phase = "R1";
        rd(4'h0, v); check("R1", v, 0);
        rd(4'h4, v); check("R1", v, 0);
        rd(4'h8, v); check("R1", v, 0);
        rd(4'hC, v); check("R1", v, 'h18);
        check("R1", int'(pwm_out), 1);

        // R5/R4: period 5, duty 2, normal levels, enabled
        phase = "R5";
        wr(4'h4, 5); wr(4'h8, 2); wr(4'hC, 'h10B);
        idle(20);
        count_high(10, h); check("R5", h, 4);

        // R3: counter write ignored
        phase = "R3";
        wr(4'h0, 32'hFFFF);
        rd(4'h0, v); check("R3", int'(v < 5), 1);
        rd(4'h4, v); check("R3", v, 5);

        // R8: unlocked change waits for wrap
        phase = "R8";
        wr(4'h8, 4);
        idle(12);
        count_high(10, h); check("R8", h, 8);

        // R6: inverted levels
        phase = "R6";
        wr(4'hC, 'h113);
        idle(12);
        count_high(10, h); check("R6", h, 2);

        // R9: lock holds running values
        phase = "R9";
        wr(4'hC, 'h153);
        wr(4'h4, 8); wr(4'h8, 1);
        rd(4'h4, v); check("R9", v, 8);
        rd(4'h8, v); check("R9", v, 1);
        idle(20);
        count_high(10, h); check("R9", h, 2);

        // R10: unlock applies period, duty and levels together
        phase = "R10";
        wr(4'hC, 'h10B);
        idle(20);
        count_high(16, h); check("R10", h, 2);

        // R5 corners: duty 0 and duty above period
        phase = "R5";
        wr(4'h8, 0); idle(20);
        count_high(16, h); check("R5", h, 0);
        wr(4'h8, 9); idle(20);
        count_high(16, h); check("R5", h, 16);

        // R4: period 1 parks the counter
        phase = "R4";
        wr(4'h4, 1); idle(20);
        for (int i = 0; i < 4; i++) begin
            rd(4'h0, v); check("R4", v, 0);
        end

        // R7: disabled, inactive low
        phase = "R7";
        wr(4'h4, 6); wr(4'h8, 3);
        wr(4'hC, 'h108);
        idle(3);
        count_high(8, h); check("R7", h, 0);
        rd(4'h0, v); check("R7", v, 0);

        // R2: control field masking
        phase = "R2";
        wr(4'hC, 32'hFFFF_FFFF);
        rd(4'hC, v); check("R2", v, 'h17F);
        wr(4'hC, 'h108);
        rd(4'hC, v); check("R2", v, 'h108);
        idle(10);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule